// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a memory access may proceed. It keeps a small table of protection regions. Each region has a configuration field and an address register. One security register holds three policy bits: lockdown, whitelist and lock bypass. A requester presents an access address, an access kind (read, write or execute), a size and the privilege level. In the same cycle the block reports a pass/fail verdict for each half of the access and one combined fault flag.

An access whose bytes run past a 4-byte word boundary is split into a low half (the word that holds the first byte) and a high half (the next word). Each half is checked against the regions on its own. Regions are matched at word granularity. Each region uses one of four matching modes. When several regions match, the one with the lowest index decides. Configuration, address and security writes arrive on simple write ports and take effect at the next rising clock edge. The access check is purely combinational on the stored state.

Top module: `pmp_checker`

## Requirements
- R1: A region config field is 6 bits: [0] read, [1] write, [2] execute, [4:3] mode, [5] lock. Mode 0 never matches. Mode 1 (range) matches word addresses w with lower <= w < own address register, where lower is the previous region's address register, or 0 for region 0.
- R2: Mode 2 matches only the one word equal to the address register. Mode 3 (power-of-two) counts the trailing ones t of the address register and matches a block of 2^(t+1) words that contains that register value.
- R3: When several regions match a half, the lowest-index matching region alone decides that half's result, whether it allows or denies.
- R4: With lockdown clear, user mode gets the region's read/write/execute bits. Machine mode gets full access to an unlocked region and the region's bits when it is locked. Access kinds: 0 read, 1 write, 2 execute; 3 is checked as read.
- R5: With lockdown clear and whitelist clear, an unmatched half passes in machine mode and fails in user mode (privilege input 1 = machine).
- R6: Sizes are 0 = byte, 1 = halfword, 2 or 3 = word. An access whose last byte lies beyond the word of its first byte is split. When there is no split, the high-half result is 1. The fault output is 1 exactly when either half fails.
- R7: While bypass is clear, a write to a locked region's config is ignored. So is a write to its address register, and a write to the address register just below a locked range-mode region. With bypass set, such writes take effect.
- R8: With lockdown clear, a config write that has write set and read clear is stored with write cleared.
- R9: Security bit [1] (whitelist) makes every unmatched machine-mode half fail. Once set, it stays set until reset.
- R10: Security bit [0] (lockdown) stays set until reset. While it is set, permissions follow the {lock,R,W,X} table: non-shared unlocked entries serve user mode only and locked ones serve machine mode only. W-without-R entries are shared (0010: M read/write, U read; 0011: both read/write; 1010: both execute; 1011: M read/execute, U execute). 1111 gives both read only.
- R11: A write that would set security bit [2] (bypass) is ignored while bypass is clear and any region is locked. Otherwise the written value is taken, so a set bypass can be cleared.
- R12: With lockdown set and whitelist clear, an unmatched machine-mode half passes for read and write and fails for execute. Unmatched user mode still fails.
- R13: After reset all regions are off with address 0 and all security bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Region config write strobe |
| cfg_idx_i | input | IDX_W | Region index for config write |
| cfg_wdata_i | input | 6 | Config write data |
| addr_we_i | input | 1 | Region address write strobe |
| addr_idx_i | input | IDX_W | Region index for address write |
| addr_wdata_i | input | ADDR_W-2 | Address register write data (word address) |
| sec_we_i | input | 1 | Security register write strobe |
| sec_wdata_i | input | 3 | Security write data: [0] lockdown, [1] whitelist, [2] bypass |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_kind_i | input | 2 | Access kind |
| acc_size_i | input | 2 | Access size |
| acc_mmode_i | input | 1 | 1 = machine mode, 0 = user mode |
| lo_ok_o | output | 1 | Low half passes |
| hi_ok_o | output | 1 | High half passes (1 when not split) |
| fault_o | output | 1 | Access fails |

## Verification
The bench targets accesses that straddle a word: a word access at offset 2 whose high half falls outside a single-word region, and a halfword at the same offset that must not split. A design that misjudged the split would pass the first or fail the second. It probes overlapping regions whose priorities both allow and deny, and the exclusive upper bound of a range region. A reversed priority or an inclusive comparison would flip those verdicts. It also drives the sticky and guarded policy writes: clearing lockdown or whitelist, enabling bypass with a locked region present, and moving an address below a locked range. A design that honoured any of these writes would then grant or deny accesses it should not.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RANGE = 2'd1,
        MODE_WORD  = 2'd2,
        MODE_POW2  = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic        lock;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } region_cfg_t;

    typedef struct packed {
        logic bypass;
        logic whitelist;
        logic lockdown;
    } sec_cfg_t;

endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_chk_pkg::*;
#(
    parameter int WORD_W = 30
) (
    input  logic              lock_i,
    input  match_mode_e       mode_i,
    input  logic [2:0]        rwx_i,
    input  logic [WORD_W-1:0] lower_i,
    input  logic [WORD_W-1:0] upper_i,
    input  logic [WORD_W-1:0] word_i,
    input  acc_kind_e         kind_i,
    input  logic              mmode_i,
    input  logic              lockdown_i,
    output logic              hit_o,
    output logic              allow_o
);
    logic [WORD_W-1:0] blk_mask;
    logic [2:0]        grant;

    assign blk_mask = upper_i ^ (upper_i + 1'b1);

    always_comb begin
        unique case (mode_i)
            MODE_RANGE: hit_o = (word_i >= lower_i) && (word_i < upper_i);
            MODE_WORD:  hit_o = (word_i == upper_i);
            MODE_POW2:  hit_o = ((word_i ^ upper_i) & ~blk_mask) == '0;
            default:    hit_o = 1'b0;
        endcase
    end

    // grant = {read, write, exec}; rwx_i = {x, w, r}
    always_comb begin
        grant = 3'b000;
        if (!lockdown_i) begin
            if (mmode_i && !lock_i) grant = 3'b111;
            else                    grant = {rwx_i[0], rwx_i[1], rwx_i[2]};
        end else if (rwx_i[1] && !rwx_i[0]) begin
            unique case ({lock_i, rwx_i[2]})
                2'b00:   grant = mmode_i ? 3'b110 : 3'b100;
                2'b01:   grant = 3'b110;
                2'b10:   grant = 3'b001;
                default: grant = mmode_i ? 3'b101 : 3'b001;
            endcase
        end else if (lock_i && (rwx_i == 3'b111)) begin
            grant = 3'b100;
        end else if (lock_i == mmode_i) begin
            grant = {rwx_i[0], rwx_i[1], rwx_i[2]};
        end
    end

    always_comb begin
        unique case (kind_i)
            ACC_WRITE: allow_o = grant[1];
            ACC_EXEC:  allow_o = grant[0];
            default:   allow_o = grant[2];
        endcase
    end
endmodule

// File: rtl/pmp_half_check.sv
module pmp_half_check
    import pmp_chk_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int WORD_W    = 30
) (
    input  region_cfg_t [N_REGIONS-1:0]             cfg_i,
    input  logic        [N_REGIONS-1:0][WORD_W-1:0] addr_i,
    input  logic        [WORD_W-1:0]                word_i,
    input  acc_kind_e                               kind_i,
    input  logic                                    mmode_i,
    input  logic                                    lockdown_i,
    input  logic                                    whitelist_i,
    output logic                                    ok_o
);
    logic [N_REGIONS-1:0] hit;
    logic [N_REGIONS-1:0] allow;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        logic [WORD_W-1:0] lower;
        if (g == 0) begin : g_first
            assign lower = '0;
        end else begin : g_rest
            assign lower = addr_i[g-1];
        end
        pmp_region_match #(.WORD_W(WORD_W)) match_i (
            .lock_i     (cfg_i[g].lock),
            .mode_i     (cfg_i[g].mode),
            .rwx_i      ({cfg_i[g].x, cfg_i[g].w, cfg_i[g].r}),
            .lower_i    (lower),
            .upper_i    (addr_i[g]),
            .word_i     (word_i),
            .kind_i     (kind_i),
            .mmode_i    (mmode_i),
            .lockdown_i (lockdown_i),
            .hit_o      (hit[g]),
            .allow_o    (allow[g])
        );
    end

    always_comb begin
        if (!mmode_i || whitelist_i) ok_o = 1'b0;
        else if (lockdown_i)         ok_o = (kind_i != ACC_EXEC);
        else                         ok_o = 1'b1;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) ok_o = allow[i];
        end
    end
endmodule

// File: rtl/pmp_regs.sv
module pmp_regs
    import pmp_chk_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int WORD_W    = 30,
    localparam int IDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic                                    cfg_we_i,
    input  logic        [IDX_W-1:0]                 cfg_idx_i,
    input  logic        [5:0]                       cfg_wdata_i,
    input  logic                                    addr_we_i,
    input  logic        [IDX_W-1:0]                 addr_idx_i,
    input  logic        [WORD_W-1:0]                addr_wdata_i,
    input  logic                                    sec_we_i,
    input  sec_cfg_t                                sec_wdata_i,
    output region_cfg_t [N_REGIONS-1:0]             cfg_o,
    output logic        [N_REGIONS-1:0][WORD_W-1:0] addr_o,
    output sec_cfg_t                                sec_o,
    output logic                                    any_locked_o
);
    typedef struct packed {
        region_cfg_t [N_REGIONS-1:0]             cfg;
        logic        [N_REGIONS-1:0][WORD_W-1:0] addr;
        sec_cfg_t                                sec;
    } state_t;

    state_t               st_d, st_q;
    region_cfg_t          new_cfg;
    logic [N_REGIONS-1:0] addr_prot;
    logic                 any_locked;

    always_comb begin
        st_d       = st_q;
        any_locked = 1'b0;
        for (int i = 0; i < N_REGIONS; i++) begin
            any_locked   = any_locked | st_q.cfg[i].lock;
            addr_prot[i] = st_q.cfg[i].lock;
        end
        for (int i = 1; i < N_REGIONS; i++) begin
            if (st_q.cfg[i].lock && (st_q.cfg[i].mode == MODE_RANGE)) addr_prot[i-1] = 1'b1;
        end

        new_cfg = region_cfg_t'(cfg_wdata_i);
        if (!st_q.sec.lockdown && new_cfg.w && !new_cfg.r) new_cfg.w = 1'b0;

        if (cfg_we_i && (int'(cfg_idx_i) < N_REGIONS)) begin
            if (!st_q.cfg[cfg_idx_i].lock || st_q.sec.bypass) st_d.cfg[cfg_idx_i] = new_cfg;
        end
        if (addr_we_i && (int'(addr_idx_i) < N_REGIONS)) begin
            if (!addr_prot[addr_idx_i] || st_q.sec.bypass) st_d.addr[addr_idx_i] = addr_wdata_i;
        end
        if (sec_we_i) begin
            st_d.sec.lockdown  = st_q.sec.lockdown  | sec_wdata_i.lockdown;
            st_d.sec.whitelist = st_q.sec.whitelist | sec_wdata_i.whitelist;
            if (st_q.sec.bypass || !any_locked) st_d.sec.bypass = sec_wdata_i.bypass;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o        = st_q.cfg;
    assign addr_o       = st_q.addr;
    assign sec_o        = st_q.sec;
    assign any_locked_o = any_locked;
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_chk_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
    localparam int WORD_W   = ADDR_W - 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [5:0]        cfg_wdata_i,
    input  logic              addr_we_i,
    input  logic [IDX_W-1:0]  addr_idx_i,
    input  logic [WORD_W-1:0] addr_wdata_i,
    input  logic              sec_we_i,
    input  logic [2:0]        sec_wdata_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [1:0]        acc_size_i,
    input  logic              acc_mmode_i,
    output logic              lo_ok_o,
    output logic              hi_ok_o,
    output logic              fault_o
);
    region_cfg_t [N_REGIONS-1:0]             cfg_q;
    logic        [N_REGIONS-1:0][WORD_W-1:0] addr_q;
    sec_cfg_t                                sec_q;
    logic                                    any_locked;
    logic [2:0]                              last_off;
    logic                                    split;
    logic [1:0][WORD_W-1:0]                  half_word;
    logic [1:0]                              half_ok;

    pmp_regs #(.N_REGIONS(N_REGIONS), .WORD_W(WORD_W)) regs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_we_i     (cfg_we_i),
        .cfg_idx_i    (cfg_idx_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .addr_we_i    (addr_we_i),
        .addr_idx_i   (addr_idx_i),
        .addr_wdata_i (addr_wdata_i),
        .sec_we_i     (sec_we_i),
        .sec_wdata_i  (sec_cfg_t'(sec_wdata_i)),
        .cfg_o        (cfg_q),
        .addr_o       (addr_q),
        .sec_o        (sec_q),
        .any_locked_o (any_locked)
    );

    always_comb begin
        unique case (acc_size_i)
            2'd0:    last_off = {1'b0, acc_addr_i[1:0]};
            2'd1:    last_off = {1'b0, acc_addr_i[1:0]} + 3'd1;
            default: last_off = {1'b0, acc_addr_i[1:0]} + 3'd3;
        endcase
    end
    assign split        = last_off[2];
    assign half_word[0] = acc_addr_i[ADDR_W-1:2];
    assign half_word[1] = acc_addr_i[ADDR_W-1:2] + 1'b1;

    for (genvar h = 0; h < 2; h++) begin : g_half
        pmp_half_check #(.N_REGIONS(N_REGIONS), .WORD_W(WORD_W)) half_i (
            .cfg_i       (cfg_q),
            .addr_i      (addr_q),
            .word_i      (half_word[h]),
            .kind_i      (acc_kind_e'(acc_kind_i)),
            .mmode_i     (acc_mmode_i),
            .lockdown_i  (sec_q.lockdown),
            .whitelist_i (sec_q.whitelist),
            .ok_o        (half_ok[h])
        );
    end

    assign lo_ok_o = half_ok[0];
    assign hi_ok_o = split ? half_ok[1] : 1'b1;
    assign fault_o = !(lo_ok_o && hi_ok_o);
endmodule

// File: rtl/pmp_checker_chk.sv
module pmp_checker_chk
    import pmp_chk_pkg::*;
#(
    parameter int N_REGIONS = 4
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input region_cfg_t [N_REGIONS-1:0] cfg_i,
    input sec_cfg_t                    sec_i,
    input logic                        any_locked_i,
    input logic [1:0]                  acc_off_i,
    input logic [1:0]                  acc_size_i,
    input logic                        hi_ok_i
);
    logic [2:0] end_byte;
    assign end_byte = {1'b0, acc_off_i} + ((acc_size_i == 2'd0) ? 3'd0 :
                                           (acc_size_i == 2'd1) ? 3'd1 : 3'd3);

    // R10
    lockdown_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_i.lockdown |=> sec_i.lockdown);

    // R9
    whitelist_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_i.whitelist |=> sec_i.whitelist);

    // R11
    bypass_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sec_i.bypass && any_locked_i) |=> !sec_i.bypass);

    // R6
    no_split_high_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !end_byte[2] |-> hi_ok_i);

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_lock
        // R7
        locked_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_i[g].lock && !sec_i.bypass) |=> $stable(cfg_i[g]));
    end
endmodule

bind pmp_checker pmp_checker_chk #(.N_REGIONS(N_REGIONS)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg_q),
    .sec_i        (sec_q),
    .any_locked_i (any_locked),
    .acc_off_i    (acc_addr_i[1:0]),
    .acc_size_i   (acc_size_i),
    .hi_ok_i      (hi_ok_o)
);

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, addr_we = 1'b0, sec_we = 1'b0;
    logic [1:0]  cfg_idx = '0, addr_idx = '0;
    logic [5:0]  cfg_wdata = '0;
    logic [29:0] addr_wdata = '0;
    logic [2:0]  sec_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0, acc_size = '0;
    logic        acc_mmode = 1'b0;
    logic        lo_ok, hi_ok, fault;

    int n_chk = 0;
    int n_err = 0;

    logic [5:0]  m_cfg [N];
    logic [29:0] m_addr[N];
    logic [2:0]  m_sec;

    always #4 clk = ~clk;

    pmp_checker dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
        .addr_we_i(addr_we), .addr_idx_i(addr_idx), .addr_wdata_i(addr_wdata),
        .sec_we_i(sec_we), .sec_wdata_i(sec_wdata),
        .acc_addr_i(acc_addr), .acc_kind_i(acc_kind), .acc_size_i(acc_size),
        .acc_mmode_i(acc_mmode),
        .lo_ok_o(lo_ok), .hi_ok_o(hi_ok), .fault_o(fault)
    );

    // ---------------- reference model ----------------
    function automatic void m_clear();
        for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
        m_sec = '0;
    endfunction

    function automatic bit m_any_lock();
        for (int i = 0; i < N; i++) if (m_cfg[i][5]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void m_cfg_wr(int idx, logic [5:0] d);
        logic [5:0] v = d;
        if (m_cfg[idx][5] && !m_sec[2]) return;
        if (!m_sec[0] && v[1] && !v[0]) v[1] = 1'b0;
        m_cfg[idx] = v;
    endfunction

    function automatic void m_addr_wr(int idx, logic [29:0] d);
        bit prot = m_cfg[idx][5];
        if (idx < N - 1) if (m_cfg[idx+1][5] && m_cfg[idx+1][4:3] == 2'd1) prot = 1'b1;
        if (prot && !m_sec[2]) return;
        m_addr[idx] = d;
    endfunction

    function automatic void m_sec_wr(logic [2:0] d);
        bit byp = m_sec[2];
        if (m_sec[2] || !m_any_lock()) byp = d[2];
        m_sec = {byp, m_sec[1] | d[1], m_sec[0] | d[0]};
    endfunction

    function automatic bit m_hit(int i, logic [29:0] w);
        longint wv = w, up = m_addr[i], lw = 0;
        int t = 0;
        if (i > 0) lw = m_addr[i-1];
        case (m_cfg[i][4:3])
            2'd1: return (wv >= lw) && (wv < up);
            2'd2: return w == m_addr[i];
            2'd3: begin
                while (t < 30 && m_addr[i][t]) t++;
                return (wv >> (t + 1)) == (up >> (t + 1));
            end
            default: return 1'b0;
        endcase
    endfunction

    // returns {read, write, exec}
    function automatic logic [2:0] m_perm(int i, bit mm);
        logic [5:0] c = m_cfg[i];
        logic [2:0] own = {c[0], c[1], c[2]};
        if (!m_sec[0]) return (mm && !c[5]) ? 3'b111 : own;
        case ({c[5], c[0], c[1], c[2]})
            4'b0010: return mm ? 3'b110 : 3'b100;
            4'b0011: return 3'b110;
            4'b1010: return 3'b001;
            4'b1011: return mm ? 3'b101 : 3'b001;
            4'b1111: return 3'b100;
            default: return (c[5] == mm) ? own : 3'b000;
        endcase
    endfunction

    function automatic bit m_half(logic [29:0] w, int kd, bit mm);
        logic [2:0] p;
        for (int i = 0; i < N; i++) begin
            if (m_hit(i, w)) begin
                p = m_perm(i, mm);
                return (kd == 1) ? p[1] : (kd == 2) ? p[0] : p[2];
            end
        end
        if (!mm || m_sec[1]) return 1'b0;
        if (m_sec[0]) return kd != 2;
        return 1'b1;
    endfunction

    // ---------------- drivers ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        m_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_cfg(int idx, logic [5:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_wdata = d;
        m_cfg_wr(idx, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_addr(int idx, logic [29:0] d);
        @(negedge clk);
        addr_we = 1'b1; addr_idx = idx[1:0]; addr_wdata = d;
        m_addr_wr(idx, d);
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic wr_sec(logic [2:0] d);
        @(negedge clk);
        sec_we = 1'b1; sec_wdata = d;
        m_sec_wr(d);
        @(negedge clk);
        sec_we = 1'b0;
    endtask

    task automatic probe(logic [31:0] a, int sz, int kd, bit mm, int exp_f, string tag);
        bit e_lo, e_hi, e_f, split;
        int nb;
        @(negedge clk);
        acc_addr = a; acc_size = sz[1:0]; acc_kind = kd[1:0]; acc_mmode = mm;
        #2;
        nb    = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        split = (int'(a[1:0]) + nb) > 4;
        e_lo  = m_half(a[31:2], kd, mm);
        e_hi  = split ? m_half(a[31:2] + 30'd1, kd, mm) : 1'b1;
        e_f   = !(e_lo && e_hi);
        n_chk++;
        if (lo_ok !== e_lo || hi_ok !== e_hi || fault !== e_f) begin
            n_err++;
            $display("FAIL %s addr=%h sz=%0d kind=%0d m=%0d: lo/hi/fault=%b%b%b expected %b%b%b",
                     tag, a, sz, kd, mm, lo_ok, hi_ok, fault, e_lo, e_hi, e_f);
        end
        if (exp_f >= 0) begin
            n_chk++;
            if (fault !== exp_f[0]) begin
                n_err++;
                $display("FAIL %s addr=%h: fault=%b expected %0d", tag, a, fault, exp_f);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_clear();
        do_reset();

        // R13 / R5: empty table after reset
        probe(32'h40, 2, 0, 1'b1, 0, "R13 reset M read");
        probe(32'h40, 2, 0, 1'b0, 1, "R5 reset U read");
        probe(32'h40, 2, 2, 1'b1, 0, "R5 reset M exec");

        // R1: range regions
        wr_addr(0, 30'h40);
        wr_cfg(0, 6'h0B);
        probe(32'h80,  2, 0, 1'b0, 0, "R1 range inside");
        probe(32'h80,  2, 2, 1'b0, 1, "R4 range no exec");
        probe(32'h100, 2, 0, 1'b0, 1, "R1 range upper exclusive");
        wr_addr(1, 30'h80);
        wr_cfg(1, 6'h0C);
        probe(32'h100, 2, 2, 1'b0, 0, "R1 range lower from prev");
        probe(32'h200, 2, 2, 1'b0, 1, "R1 range above");

        // R2: single word and power-of-two
        do_reset();
        wr_addr(2, 30'h50);
        wr_cfg(2, 6'h11);
        probe(32'h140, 2, 0, 1'b0, 0, "R2 word hit");
        probe(32'h144, 2, 0, 1'b0, 1, "R2 word miss");
        wr_addr(3, 30'h63);
        wr_cfg(3, 6'h19);
        probe(32'h19C, 2, 0, 1'b0, 0, "R2 pow2 top");
        probe(32'h180, 2, 0, 1'b0, 0, "R2 pow2 base");
        probe(32'h1A0, 2, 0, 1'b0, 1, "R2 pow2 above");
        probe(32'h17C, 2, 0, 1'b0, 1, "R2 pow2 below");

        // R3: priority both ways
        do_reset();
        wr_addr(0, 30'h50); wr_cfg(0, 6'h11);
        wr_addr(1, 30'h53); wr_cfg(1, 6'h18);
        probe(32'h140, 2, 0, 1'b0, 0, "R3 high prio allows");
        probe(32'h144, 2, 0, 1'b0, 1, "R3 low prio denies");
        wr_cfg(0, 6'h10); wr_cfg(1, 6'h1B);
        probe(32'h140, 2, 0, 1'b0, 1, "R3 high prio denies");
        probe(32'h144, 2, 0, 1'b0, 0, "R3 low prio allows");

        // R6: split accesses
        do_reset();
        wr_addr(0, 30'h50); wr_cfg(0, 6'h13);
        probe(32'h142, 2, 0, 1'b0, 1, "R6 word crosses out");
        probe(32'h142, 1, 0, 1'b0, 0, "R6 half fits");
        probe(32'h143, 0, 1, 1'b0, 0, "R6 byte end of word");
        probe(32'h13E, 1, 0, 1'b0, 1, "R6 low half outside");
        wr_addr(1, 30'h51); wr_cfg(1, 6'h13);
        probe(32'h142, 3, 1, 1'b0, 0, "R6 both halves ok");

        // R7 / R4: locks
        do_reset();
        wr_addr(0, 30'h50); wr_cfg(0, 6'h31);
        probe(32'h140, 2, 1, 1'b1, 1, "R4 locked M write");
        probe(32'h140, 2, 0, 1'b1, 0, "R4 locked M read");
        wr_cfg(0, 6'h33);
        probe(32'h140, 2, 1, 1'b1, 1, "R7 locked cfg ignored");
        wr_addr(0, 30'h60);
        probe(32'h140, 2, 1, 1'b1, 1, "R7 locked addr ignored");
        wr_addr(3, 30'h70); wr_addr(2, 30'h60); wr_cfg(3, 6'h29);
        probe(32'h180, 2, 2, 1'b1, 1, "R7 locked range M exec");
        wr_addr(2, 30'h68);
        probe(32'h180, 2, 2, 1'b1, 1, "R7 range lower addr ignored");

        // R11: bypass
        wr_sec(3'b100);
        wr_cfg(0, 6'h33);
        probe(32'h140, 2, 1, 1'b1, 1, "R11 bypass refused");
        do_reset();
        wr_sec(3'b100);
        wr_addr(0, 30'h50); wr_cfg(0, 6'h31);
        wr_cfg(0, 6'h33);
        probe(32'h140, 2, 1, 1'b1, 0, "R7 bypass allows edit");
        wr_sec(3'b000);
        wr_cfg(0, 6'h31);
        probe(32'h140, 2, 1, 1'b1, 0, "R11 bypass cleared");

        // R8: reserved combination
        do_reset();
        wr_addr(0, 30'h50); wr_cfg(0, 6'h12);
        probe(32'h140, 2, 1, 1'b0, 1, "R8 W-only stored without W");
        probe(32'h140, 2, 0, 1'b0, 1, "R8 no read either");

        // R9: whitelist
        do_reset();
        wr_addr(0, 30'h50); wr_cfg(0, 6'h10);
        probe(32'h140, 2, 1, 1'b1, 0, "R4 unlocked M full");
        wr_sec(3'b010);
        probe(32'h40, 2, 0, 1'b1, 1, "R9 whitelist M unmatched");
        wr_sec(3'b000);
        probe(32'h40, 2, 0, 1'b1, 1, "R9 whitelist sticky");

        // R10 / R12: lockdown
        do_reset();
        wr_sec(3'b001);
        probe(32'h40, 2, 0, 1'b1, 0, "R12 M unmatched read");
        probe(32'h40, 2, 2, 1'b1, 1, "R12 M unmatched exec");
        probe(32'h40, 2, 0, 1'b0, 1, "R12 U unmatched");
        wr_addr(0, 30'h50); wr_cfg(0, 6'h13);
        probe(32'h140, 2, 0, 1'b1, 1, "R10 M on user region");
        probe(32'h140, 2, 0, 1'b0, 0, "R10 U on user region");
        wr_addr(1, 30'h51); wr_cfg(1, 6'h35);
        probe(32'h144, 2, 2, 1'b1, 0, "R10 M on machine region");
        probe(32'h144, 2, 2, 1'b0, 1, "R10 U on machine region");
        wr_addr(2, 30'h52); wr_cfg(2, 6'h12);
        probe(32'h148, 2, 1, 1'b1, 0, "R10 shared M write");
        probe(32'h148, 2, 1, 1'b0, 1, "R10 shared U write");
        probe(32'h148, 2, 0, 1'b0, 0, "R10 shared U read");
        wr_sec(3'b000);
        probe(32'h40, 2, 2, 1'b1, 1, "R10 lockdown sticky");

        // random mix (R1 to R12 together)
        do_reset();
        for (int it = 0; it < 3000; it++) begin
            int sel = $urandom_range(0, 15);
            if (it % 256 == 255) do_reset();
            else if (sel < 3) wr_cfg($urandom_range(0, N - 1), 6'($urandom()));
            else if (sel < 5) wr_addr($urandom_range(0, N - 1), 30'($urandom_range(0, 127)));
            else if (sel == 5) wr_sec(3'($urandom()));
            else probe(32'($urandom_range(0, 511)), $urandom_range(0, 3),
                       $urandom_range(0, 3), 1'($urandom()), -1, "random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule